// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block is the register side of a 256-entry colour lookup table for an indexed-colour display. Software reaches it through a 16-byte register window. A write to the index register picks the table entry. Writes to the colour register then deliver the red, green and blue components of that entry in turn. When the blue component has been stored, the entry pointer moves on by one, so a run of colour writes can load consecutive entries without reloading the index.

The table is held as three 256 x 8 component arrays. A separate read port, used by the display scan-out, gives the 24-bit colour of any entry without waiting for a clock. Register reads carry no information and always return zero.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads back as colour 0x000000 on the scan-out port, except entry 255, which reads 0xFFFFFF. The component sequence starts at red and the entry pointer is 0.
- R2: An accepted write to offset 0x0 (the index register) loads the entry pointer from bits 31:24 of the write data and returns the component sequence to red.
- R3: Accepted writes to offset 0x4 (the colour register) store bits 31:24 of the write data into the red, then green, then blue component of the entry under the pointer, rotating in that order. Each write changes only that one component of that one entry.
- R4: The accepted write that stores the blue component advances the entry pointer by one, wrapping from 255 to 0.
- R5: A write is accepted only when all four byte enables are set (bus_be = 4'b1111) and bus_addr[1:0] = 2'b00. Any other write leaves the table, the pointer and the component sequence unchanged.
- R6: A read of any offset in the window returns 0 on bus_rdata and changes nothing.
- R7: Accepted writes to offsets 0x8 and 0xC change nothing.
- R8: pix_rgb gives {red, green, blue} of entry pix_idx, red in bits 23:16 and blue in bits 7:0. The value follows pix_idx within the same cycle, and a stored component appears from the clock edge that accepts its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access to the register window is active this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset inside the 16-byte window |
| bus_be | input | 4 | Byte enables; all four must be set for a write to count |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Table entry requested by scan-out |
| pix_rgb | output | 24 | Colour of entry pix_idx, {red, green, blue} |

## Verification
Directed patterns come first. A full triplet at entry 254 followed by one at 255 shows the pointer running on and wrapping to 0. An index write in the middle of a triplet shows the sequence returning to red. Writes with partial byte enables, with an unaligned offset, and to the two unused offsets each have to leave the following colour write landing where it would have landed without them. A long random mix of index writes, colour writes, malformed writes and reads is then compared with a bench model of the three arrays at both the entry just written and a random entry. Together these separate a wrong component order, a wrong increment point, a missing wrap and a write that reaches the wrong entry.

// File: rtl/clut_pkg.sv
// Package: shared sizes and the component phase type for the lookup-table loader.
// Assumes three components per entry, always stored in the order red, green, blue.
package clut_pkg;
    localparam int NUM_LANES = 3;

    // Which component the next colour-register write stores.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_phase_t;
endpackage

// File: rtl/clut_lane.sv
// Module: one component array of the lookup table (DEPTH x WIDTH).
// One synchronous write port and one combinational read port for scan-out.
// Assumes DEPTH is a power of two. Reset clears every entry except the last,
// which is set to all ones.
module clut_lane #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage: reset to black with a white last entry, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == DEPTH - 1) ? {WIDTH{1'b1}} : '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Scan-out read: no clock between address and data.
    always_comb rdata = mem[raddr];

    // R3: a write lands at the addressed entry with the offered value.
    a_r3_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/clut_wr_seq.sv
// Module: write sequencer. Holds the entry pointer and the component phase,
// and turns decoded index and colour writes into one-lane write strobes.
// Assumes idx_load and col_load are never high together.
module clut_wr_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_load,
    input  logic                 col_load,
    input  logic [COMP_W-1:0]    wr_byte,
    output logic [NUM_LANES-1:0] lane_we,
    output logic [IDX_W-1:0]     lane_idx,
    output logic [COMP_W-1:0]    lane_data
);
    logic [IDX_W-1:0] idx_q;
    comp_phase_t      ph_q;

    // Pointer and phase: load on index write, rotate and advance on colour write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ph_q  <= PH_RED;
        end else if (idx_load) begin
            idx_q <= wr_byte[COMP_W-1 -: IDX_W];
            ph_q  <= PH_RED;
        end else if (col_load) begin
            unique case (ph_q)
                PH_RED:  ph_q <= PH_GRN;
                PH_GRN:  ph_q <= PH_BLU;
                default: begin
                    ph_q  <= PH_RED;
                    idx_q <= idx_q + 1'b1;
                end
            endcase
        end
    end

    // Strobe the lane matching the current phase.
    always_comb begin
        lane_we = '0;
        if (col_load) begin
            unique case (ph_q)
                PH_RED:  lane_we[0] = 1'b1;
                PH_GRN:  lane_we[1] = 1'b1;
                default: lane_we[2] = 1'b1;
            endcase
        end
    end

    assign lane_idx  = idx_q;
    assign lane_data = wr_byte;

    // R2: index write loads pointer and restarts at red.
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (idx_q == $past(wr_byte[COMP_W-1 -: IDX_W])) && (ph_q == PH_RED));

    // R3: phase rotates red -> green -> blue -> red on each colour write.
    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && ph_q == PH_RED) |=> ph_q == PH_GRN);
    a_r3_rotate_g: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && ph_q == PH_GRN) |=> (ph_q == PH_BLU) && $stable(idx_q));

    // R3: at most one lane written per cycle.
    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_we));

    // R4: blue write advances the pointer, wrapping at the top.
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && ph_q == PH_BLU) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

    // R5/R7: with no decoded write, pointer and phase hold.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_load && !col_load) |=> $stable(idx_q) && $stable(ph_q));
endmodule

// File: rtl/clut_loader.sv
// Module: top of the colour lookup-table loader. Decodes the 16-byte register
// window (offset 0x0 index, 0x4 colour, 0x8/0xC inert), accepts only full
// aligned 32-bit writes, and serves a combinational {R,G,B} scan-out port.
// Assumes the bus presents one access per cycle with bus_sel high.
module clut_loader
    import clut_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 256,
    parameter int COMP_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BE_W   = DATA_W / 8,
    localparam int RGB_W  = NUM_LANES * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    localparam logic [ADDR_W-3:0] REG_INDEX = '0;
    localparam logic [ADDR_W-3:0] REG_COLOR = (ADDR_W-2)'(1);

    logic                 wr_ok;
    logic                 idx_load;
    logic                 col_load;
    logic [COMP_W-1:0]    wr_byte;
    logic [NUM_LANES-1:0] lane_we;
    logic [IDX_W-1:0]     lane_idx;
    logic [COMP_W-1:0]    lane_data;
    logic                 unused_bits;

    // Decode: a full-width aligned write selects one of the registers.
    always_comb begin
        wr_ok    = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}}) && (bus_addr[1:0] == 2'b00);
        idx_load = wr_ok && (bus_addr[ADDR_W-1:2] == REG_INDEX);
        col_load = wr_ok && (bus_addr[ADDR_W-1:2] == REG_COLOR);
        wr_byte  = bus_wdata[DATA_W-1 -: COMP_W];
    end

    assign unused_bits = ^{bus_wdata[DATA_W-COMP_W-1:0]};

    // Register reads carry no data.
    assign bus_rdata = '0;

    clut_wr_seq #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_load  (idx_load),
        .col_load  (col_load),
        .wr_byte   (wr_byte),
        .lane_we   (lane_we),
        .lane_idx  (lane_idx),
        .lane_data (lane_data)
    );

    // One array per component; lane 0 (red) feeds the top byte of pix_rgb.
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        clut_lane #(
            .DEPTH (ENTRIES),
            .WIDTH (COMP_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[k]),
            .waddr (lane_idx),
            .wdata (lane_data),
            .raddr (pix_idx),
            .rdata (pix_rgb[COMP_W*(NUM_LANES-k)-1 -: COMP_W])
        );
    end

    // R5: a malformed write never strobes a lane.
    a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != {BE_W{1'b1}}) |-> lane_we == '0);

    // R6: a read never strobes a lane.
    a_r6_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> lane_we == '0);
endmodule

// File: tb/sim_clut_loader.sv
// Bench: directed corner cases then a seeded random mix, checked against a
// bench model of the three component arrays, pointer and phase.
module sim_clut_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int tests = 0;
    int fails = 0;

    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    logic [7:0] m_idx;
    int         m_ph;

    clut_loader u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] exp_rgb(input logic [7:0] i);
        return {mr[i], mg[i], mb[i]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            mr[i] = (i == 255) ? 8'hFF : 8'h00;
            mg[i] = mr[i];
            mb[i] = mr[i];
        end
        m_idx = 8'd0;
        m_ph  = 0;
    endtask

    task automatic check_pix(input logic [7:0] i, input string req);
        pix_idx = i;
        #1;
        tests++;
        if (pix_rgb !== exp_rgb(i)) begin
            fails++;
            $display("FAIL %s entry %0d: got %06h expected %06h", req, i, pix_rgb, exp_rgb(i));
        end
    endtask

    // Drive one write at the negedge; the next posedge commits it.
    task automatic bus_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (be == 4'hF && a[1:0] == 2'b00) begin
            if (a[3:2] == 2'd0) begin
                m_idx = d[31:24];
                m_ph  = 0;
            end else if (a[3:2] == 2'd1) begin
                case (m_ph)
                    0: mr[m_idx] = d[31:24];
                    1: mg[m_idx] = d[31:24];
                    default: mb[m_idx] = d[31:24];
                endcase
                if (m_ph == 2) m_idx = m_idx + 8'd1;
                m_ph = (m_ph + 1) % 3;
            end
        end
    endtask

    task automatic bus_read_check(input logic [3:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
        #1;
        tests++;
        if (bus_rdata !== 32'h0) begin
            fails++;
            $display("FAIL R6 read offset %0h: got %08h expected 00000000", a, bus_rdata);
        end
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Write a triplet to entry e via index + three colour writes.
    task automatic load_entry(input logic [7:0] e, input logic [23:0] c);
        bus_write(4'h0, 4'hF, {e, 24'h123456});
        bus_write(4'h4, 4'hF, {c[23:16], 24'h0});
        bus_write(4'h4, 4'hF, {c[15:8], 24'hFFFFFF});
        bus_write(4'h4, 4'hF, {c[7:0], 24'h0});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents over the whole table.
        for (int i = 0; i < 256; i++) check_pix(8'(i), "R1");

        // R1: pointer 0 and red phase after reset.
        bus_write(4'h4, 4'hF, 32'hA1000000);
        check_pix(8'd0, "R1 pointer/phase");

        // R3/R8: full triplet at 254, then continue into 255 (R4).
        load_entry(8'd254, 24'h11_22_33);
        check_pix(8'd254, "R3");
        bus_write(4'h4, 4'hF, 32'h44000000);
        check_pix(8'd255, "R4 advance");
        bus_write(4'h4, 4'hF, 32'h55000000);
        bus_write(4'h4, 4'hF, 32'h66000000);
        bus_write(4'h4, 4'hF, 32'h77000000);
        check_pix(8'd0, "R4 wrap to 0");
        check_pix(8'd255, "R3");

        // R2: index write mid-triplet restarts at red.
        bus_write(4'h0, 4'hF, 32'h10000000);
        bus_write(4'h4, 4'hF, 32'h88000000);
        bus_write(4'h0, 4'hF, 32'h20000000);
        bus_write(4'h4, 4'hF, 32'h99000000);
        check_pix(8'h10, "R2");
        check_pix(8'h20, "R2 restart red");

        // R5: partial enables and unaligned offset ignored.
        bus_write(4'h4, 4'h7, 32'hEE000000);
        bus_write(4'h4, 4'hE, 32'hEE000000);
        bus_write(4'h5, 4'hF, 32'hEE000000);
        bus_write(4'h1, 4'hF, 32'h30000000);
        check_pix(8'h20, "R5 ignored");
        bus_write(4'h4, 4'hF, 32'hBB000000);
        check_pix(8'h20, "R5 phase kept");

        // R7: writes to 0x8 and 0xC inert.
        bus_write(4'h8, 4'hF, 32'hCC000000);
        bus_write(4'hC, 4'hF, 32'hCC000000);
        bus_write(4'h4, 4'hF, 32'hDD000000);
        check_pix(8'h20, "R7 inert");

        // R6: reads return zero and do not disturb.
        for (int a = 0; a < 16; a += 4) bus_read_check(4'(a));
        bus_write(4'h4, 4'hF, 32'h5A000000);
        check_pix(8'h21, "R6 no side effect");

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            int unsigned kind;
            kind = $urandom_range(0, 9);
            if (kind < 2)      bus_write(4'h0, 4'hF, $urandom());
            else if (kind < 7) bus_write(4'h4, 4'hF, $urandom());
            else if (kind < 8) bus_write(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), $urandom());
            else               bus_read_check(4'($urandom_range(0, 15)));
            check_pix(m_idx, "R3 random");
            check_pix(m_idx - 8'd1, "R4 random");
            check_pix(8'($urandom_range(0, 255)), "R8 random");
        end

        // R1: reset again restores defaults.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        check_pix(8'd0, "R1 re-reset");
        check_pix(8'd255, "R1 re-reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule